// File: doc/BRIEF.md
# Fully Associative Instruction Cache Tag Engine with Switchable Eviction

This block is the lookup and replacement core of a small instruction cache. The cache is fully associative, so any address may sit in any line. Each line stores one 32-bit instruction word, and the tag is the whole word address, meaning the byte address with bits [1:0] dropped. A requester presents a byte address. One cycle later the block either answers with a hit and the stored word, or raises a refill request toward a backing store. That store returns the word one cycle after the request. The block then writes the word into a chosen line and answers with a miss.

Victim selection follows a single runtime input. With the input low, the line touched longest ago is replaced (least recently used). With the input high, the line touched last is replaced (most recently used). The high setting lets a loop body larger than the cache keep part of itself resident instead of evicting every line just before it is needed again. Each line carries a recency rank, which the block updates on every hit and every fill. Two saturating counters record hits and misses.

Top module: `fa_icache_repl`

## Requirements
- R1: After a synchronous active-high reset, every line is invalid, both counters read zero, `resp_valid` and `fill_req` are low and `req_ready` is high.
- R2: A request accepted (`req_valid` and `req_ready` high at a clock edge) whose word address matches a valid line produces `resp_valid=1`, `resp_hit=1` and that line's word in the next cycle. Byte addresses that differ only in bits [1:0] map to the same line.
- R3: A request that matches no valid line raises `fill_req` in the next cycle, with `fill_addr` equal to the request address with bits [1:0] cleared. In the cycle after that, `resp_valid=1`, `resp_hit=0` and `resp_data` equals the returned `fill_data`, and the word is stored.
- R4: While any line is invalid, a miss fills the invalid line with the lowest index, and no valid line is evicted.
- R5: With `mode_mru=0` and all lines valid, a miss replaces the line whose last hit or fill is the oldest.
- R6: With `mode_mru=1` and all lines valid, a miss replaces the line whose last hit or fill is the most recent.
- R7: A loop of 16 sequential words (64 bytes) takes no misses after its first pass under either setting of `mode_mru`.
- R8: With `mode_mru=0`, loops of 48 and 80 sequential words (192 and 320 bytes) miss on every access once past their first pass.
- R9: `hit_count` increases by one for each hit response and `miss_count` by one for each miss. Each counter stops at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_mru | input | 1 | Eviction choice: 0 replaces least recent, 1 replaces most recent |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 32 | Byte address of the lookup |
| req_ready | output | 1 | High when a new lookup can be taken |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | 1 for hit, 0 for miss (valid with resp_valid) |
| resp_data | output | 32 | Instruction word for the response |
| fill_req | output | 1 | Refill request to backing store |
| fill_addr | output | 32 | Word-aligned refill address |
| fill_data | input | 32 | Refill word, present the cycle after fill_req |
| hit_count | output | 32 | Saturating hit counter |
| miss_count | output | 32 | Saturating miss counter |

## Verification
The sharpest corner cases are loops just under and above the 32-line capacity. A rank update that forgets to age the younger lines would leave a 16-word loop missing on later passes, or let a 48-word loop in least-recent mode score hits. Directed sequences fill all 32 lines and then touch selected words to set up a known order. They then show which word a miss removes in each mode, so a tracker that evicts the wrong end, or that evicts a valid line while an invalid one remains, makes a word miss that should hit. A reference model built on access timestamps predicts every response in the long loop runs, which also catches a wrong refill address or a stale word returned on a miss.

// File: rtl/fac_pkg.sv
package fac_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LINE_BYTES = 4;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int TAG_W      = ADDR_W - OFS_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2
    } fac_state_e;

    typedef enum logic {
        POL_OLDEST = 1'b0,
        POL_NEWEST = 1'b1
    } fac_policy_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             hit;
    } fac_lookup_t;

    function automatic logic [TAG_W-1:0] addr_to_tag(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic logic [ADDR_W-1:0] tag_to_addr(input logic [TAG_W-1:0] t);
        return {t, {OFS_W{1'b0}}};
    endfunction

endpackage

// File: rtl/fac_tag_array.sv
module fac_tag_array #(
    parameter int WAYS   = 32,
    parameter int TAG_W  = 30,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [WAYS-1:0]   valid_vec,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    logic [WAYS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [WAYS];
    logic [DATA_W-1:0] data_q [WAYS];
    logic [WAYS-1:0]   match_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
            data_q[wr_idx]  <= wr_data;
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match_vec[g] = valid_q[g] && (tag_q[g] == lk_tag);
    end

    always_comb begin
        lk_idx = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match_vec[i]) lk_idx = IDX_W'(i);
        end
    end

    assign lk_hit    = |match_vec;
    assign valid_vec = valid_q;
    assign rd_data   = data_q[rd_idx];

    // R2: a word address may live in at most one line
    assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

endmodule

// File: rtl/fac_age_tracker.sv
module fac_age_tracker
    import fac_pkg::*;
#(
    parameter int WAYS  = 32,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  fac_policy_e      policy,
    input  logic [WAYS-1:0]  valid_vec,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);

    localparam logic [IDX_W-1:0] RANK_OLDEST = IDX_W'(WAYS - 1);

    logic [IDX_W-1:0] rank_q [WAYS];
    logic [IDX_W-1:0] touched_rank;
    logic [WAYS-1:0]  newest_vec;
    logic [WAYS-1:0]  oldest_vec;

    assign touched_rank = rank_q[touch_idx];

    for (genvar g = 0; g < WAYS; g++) begin : g_rank
        always_ff @(posedge clk) begin
            if (rst) begin
                rank_q[g] <= IDX_W'(g);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(g)) begin
                    rank_q[g] <= '0;
                end else if (rank_q[g] < touched_rank) begin
                    rank_q[g] <= rank_q[g] + 1'b1;
                end
            end
        end
        assign newest_vec[g] = (rank_q[g] == '0);
        assign oldest_vec[g] = (rank_q[g] == RANK_OLDEST);
    end

    logic [IDX_W-1:0] free_idx;
    logic             free_any;
    logic [IDX_W-1:0] pol_idx;

    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    always_comb begin
        pol_idx = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (policy == POL_NEWEST) begin
                if (newest_vec[i]) pol_idx = IDX_W'(i);
            end else begin
                if (oldest_vec[i]) pol_idx = IDX_W'(i);
            end
        end
    end

    assign victim_idx = free_any ? free_idx : pol_idx;

    // R5: exactly one line holds the newest rank and one the oldest
    assert_rank_newest_unique_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(newest_vec) == 1);
    assert_rank_oldest_unique_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1);
    // R6: a touched line is the newest one afterwards
    assert_touch_newest_R6: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> rank_q[$past(touch_idx)] == '0);

endmodule

// File: rtl/fac_sat_counter.sv
module fac_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    logic [W-1:0] count_q;
    logic         at_max;

    assign at_max = &count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (inc && !at_max) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    // R9: a full counter never wraps
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        at_max |=> &count_q);

endmodule

// File: rtl/fa_icache_repl.sv
module fa_icache_repl
    import fac_pkg::*;
#(
    parameter int CACHE_BYTES = 128,
    parameter int CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_mru,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int WAYS  = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W = $clog2(WAYS);

    fac_state_e       state_q;
    fac_lookup_t      look_q;
    logic [IDX_W-1:0] hit_idx_q;

    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic [WAYS-1:0]  valid_vec;
    logic [DATA_W-1:0] rd_data;
    logic [IDX_W-1:0] victim_idx;
    logic             take_req;
    logic             in_look;
    logic             in_fill;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;

    assign take_req = req_valid && (state_q == ST_IDLE);
    assign in_look  = (state_q == ST_LOOK);
    assign in_fill  = (state_q == ST_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            look_q    <= '0;
            hit_idx_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (take_req) begin
                    state_q    <= ST_LOOK;
                    look_q.tag <= addr_to_tag(req_addr);
                    look_q.hit <= lk_hit;
                    hit_idx_q  <= lk_idx;
                end
                ST_LOOK: state_q <= look_q.hit ? ST_IDLE : ST_FILL;
                ST_FILL: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    fac_tag_array #(
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_tags (
        .clk       (clk),
        .rst       (rst),
        .lk_tag    (addr_to_tag(req_addr)),
        .lk_hit    (lk_hit),
        .lk_idx    (lk_idx),
        .valid_vec (valid_vec),
        .rd_idx    (hit_idx_q),
        .rd_data   (rd_data),
        .wr_en     (in_fill),
        .wr_idx    (victim_idx),
        .wr_tag    (look_q.tag),
        .wr_data   (fill_data)
    );

    assign touch_en  = (in_look && look_q.hit) || in_fill;
    assign touch_idx = in_fill ? victim_idx : hit_idx_q;

    fac_age_tracker #(
        .WAYS  (WAYS),
        .IDX_W (IDX_W)
    ) u_ages (
        .clk        (clk),
        .rst        (rst),
        .policy     (fac_policy_e'(mode_mru)),
        .valid_vec  (valid_vec),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    fac_sat_counter #(.W(CNT_W)) u_hits (
        .clk   (clk),
        .rst   (rst),
        .inc   (in_look && look_q.hit),
        .count (hit_count)
    );

    fac_sat_counter #(.W(CNT_W)) u_misses (
        .clk   (clk),
        .rst   (rst),
        .inc   (in_look && !look_q.hit),
        .count (miss_count)
    );

    assign req_ready  = (state_q == ST_IDLE);
    assign resp_valid = (in_look && look_q.hit) || in_fill;
    assign resp_hit   = in_look && look_q.hit;
    assign resp_data  = in_fill ? fill_data : rd_data;
    assign fill_req   = in_look && !look_q.hit;
    assign fill_addr  = tag_to_addr(look_q.tag);

    // R2/R3: every accepted request is answered or refilled next cycle
    assert_req_answered_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (resp_valid || fill_req));
    // R3: a refill request is followed by a miss response
    assert_fill_then_miss_R3: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> (resp_valid && !resp_hit));
    // R4: no valid line is evicted while an invalid one remains
    assert_invalid_first_R4: assert property (@(posedge clk) disable iff (rst)
        (in_fill && !(&valid_vec)) |-> !valid_vec[victim_idx]);
    // R1: no new request is taken while a response is pending
    assert_busy_no_ready_R1: assert property (@(posedge clk) disable iff (rst)
        (resp_valid || fill_req) |-> !req_ready);

endmodule

// File: tb/sim_fa_icache_repl.sv
module sim_fa_icache_repl;

    localparam int CLK_PERIOD = 10;
    localparam int WAYS       = 32;
    localparam logic [31:0] BASE = 32'h0000_1000;

    localparam int ROWS = 6;
    localparam int T_MODE   [ROWS] = '{0, 0, 0, 1, 1, 1};
    localparam int T_WORDS  [ROWS] = '{16, 48, 80, 16, 48, 80};
    localparam int T_PASSES [ROWS] = '{3, 3, 3, 3, 4, 3};
    localparam int T_EXPMIS [ROWS] = '{0, 48, 80, 0, -1, -1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_mru = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, resp_valid, resp_hit, fill_req;
    logic [31:0] resp_data, fill_addr, hit_count, miss_count;
    logic [31:0] fill_data = '0;

    int checks = 0;
    int errors = 0;
    int obs_miss = 0;

    fa_icache_repl u0 (
        .clk(clk), .rst(rst), .mode_mru(mode_mru),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_data(fill_data),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    always @(posedge clk) fill_data <= mem_word(fill_addr);

    // reference model: timestamps per line
    logic [29:0] m_tag   [WAYS];
    bit          m_valid [WAYS];
    int          m_stamp [WAYS];
    int          m_now, m_hits, m_misses;

    task automatic model_clear();
        for (int i = 0; i < WAYS; i++) begin
            m_valid[i] = 0;
            m_stamp[i] = 0;
        end
        m_now = 0; m_hits = 0; m_misses = 0;
    endtask

    function automatic bit model_access(input logic [31:0] a, input bit mru);
        int v;
        m_now++;
        for (int i = 0; i < WAYS; i++) begin
            if (m_valid[i] && m_tag[i] == a[31:2]) begin
                m_stamp[i] = m_now;
                m_hits++;
                return 1'b1;
            end
        end
        v = -1;
        for (int i = 0; i < WAYS; i++)
            if (v < 0 && !m_valid[i]) v = i;
        if (v < 0) begin
            v = 0;
            for (int i = 1; i < WAYS; i++) begin
                if (mru ? (m_stamp[i] > m_stamp[v]) : (m_stamp[i] < m_stamp[v])) v = i;
            end
        end
        m_valid[v] = 1;
        m_tag[v]   = a[31:2];
        m_stamp[v] = m_now;
        m_misses++;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // exp: -1 use model, 0 expect miss, 1 expect hit
    task automatic do_access(input logic [31:0] a, input int exp, input string rq);
        bit mh, exp_hit, got_hit;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        mh = model_access(a, mode_mru);
        exp_hit = (exp < 0) ? mh : exp[0];
        got_hit = resp_valid && resp_hit;
        chk(got_hit == exp_hit, rq, "hit/miss", 32'(got_hit), 32'(exp_hit));
        if (!resp_valid) begin
            chk(fill_req == 1'b1, "R3", "fill_req", 32'(fill_req), 32'd1);
            chk(fill_addr == {a[31:2], 2'b00}, "R3", "fill_addr", fill_addr, {a[31:2], 2'b00});
            @(negedge clk);
            chk(resp_valid && !resp_hit, "R3", "miss response", {30'd0, resp_valid, resp_hit}, 32'd2);
            obs_miss++;
        end
        chk(resp_data == mem_word({a[31:2], 2'b00}), got_hit ? "R2" : "R3", "data",
            resp_data, mem_word({a[31:2], 2'b00}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        string rq;
        do_reset();
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0 && fill_req == 1'b0, "R1", "resp/fill idle",
            {30'd0, resp_valid, fill_req}, 32'd0);
        chk(hit_count == 0 && miss_count == 0, "R1", "counters", hit_count | miss_count, 32'd0);

        // table walk over loop sizes and modes
        for (int r = 0; r < ROWS; r++) begin
            do_reset();
            mode_mru = T_MODE[r][0];
            rq = (T_EXPMIS[r] == 0) ? "R7" : (T_MODE[r] == 0 ? "R8" : "R6");
            for (int p = 0; p < T_PASSES[r]; p++) begin
                obs_miss = 0;
                for (int w = 0; w < T_WORDS[r]; w++)
                    do_access(BASE + 32'(4 * w), -1, rq);
            end
            if (T_EXPMIS[r] >= 0)
                chk(obs_miss == T_EXPMIS[r], rq, "last pass misses", 32'(obs_miss), 32'(T_EXPMIS[r]));
            else
                chk(obs_miss < T_WORDS[r], "R6", "newest eviction keeps part of loop",
                    32'(obs_miss), 32'(T_WORDS[r] - 1));
            @(negedge clk);
            chk(hit_count == 32'(m_hits), "R9", "hit_count", hit_count, 32'(m_hits));
            chk(miss_count == 32'(m_misses), "R9", "miss_count", miss_count, 32'(m_misses));
        end

        // R4 and R5: fill all lines, then evict the oldest
        do_reset();
        mode_mru = 1'b0;
        for (int w = 0; w < WAYS; w++) do_access(32'h2000 + 32'(4 * w), 0, "R4");
        for (int w = 0; w < WAYS; w++) do_access(32'h2000 + 32'(4 * w), 1, "R4");
        do_access(32'h2000, 1, "R5");
        do_access(32'h3000, 0, "R5");
        do_access(32'h2008, 1, "R5");
        do_access(32'h2004, 0, "R5");
        do_access(32'h2000, 1, "R5");
        do_access(32'h3000, 1, "R5");

        // R6 and R2: newest eviction, byte offset aliasing
        do_reset();
        mode_mru = 1'b1;
        for (int w = 0; w < WAYS; w++) do_access(32'h4000 + 32'(4 * w), 0, "R4");
        do_access(32'h5000, 0, "R6");
        do_access(32'h4078, 1, "R6");
        do_access(32'h407C, 0, "R6");
        do_access(32'h4078, 0, "R6");
        do_access(32'h4003, 1, "R2");
        do_access(32'h4001, 1, "R2");
        do_access(32'h5000, 1, "R6");
        @(negedge clk);
        chk(hit_count == 32'(m_hits), "R9", "hit_count directed", hit_count, 32'(m_hits));
        chk(miss_count == 32'(m_misses), "R9", "miss_count directed", miss_count, 32'(m_misses));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule